// File: doc/BRIEF.md
# SDRAM Data-Side Beat Aligner

This block is the data half of a single-data-rate SDRAM controller. The command sequencer decides when read, write and burst-stop commands go out. This block is told about each command in the same cycle and handles everything that happens on the data pins.

For reads, it waits the programmed CAS latency and then samples one word per clock from the DQ input for the programmed burst length. It hands each word to the client with a strobe and a per-byte valid flag. For writes, it drives the client's write data onto DQ, starting in the command cycle, and raises a ready strobe for every beat. It also owns the DQ output enable.

The block produces the DQM pin value. During write beats the client's write mask goes out in the same clock, so it masks that clock's data. At all other times the client's read-mask request goes out, and it blanks the word the memory returns two clocks later. A word blanked this way still counts as a beat, but its byte valid flags are cleared.

A write command that arrives while read data is still due is held back. It is also held back when it lands in the clock right after the last read sample. Either way, the bus gets one idle clock before this block drives it.

Top module: `sdr_dpath`

## Requirements
- R1: During reset and in the first cycle after it, `rd_strobe`, `rd_byte_vld`, `dq_oe` and `wr_ready` are all low.
- R2: A read command sampled in cycle k makes the block sample `dq_i` in cycle k+CL, where CL is 3 when `cfg_cl3` is 1 and 2 when it is 0. That word appears on `rd_data` with `rd_strobe` high in cycle k+CL+1.
- R3: `cfg_bl`, captured with the command, gives the burst length as 1, 2, 4 or 8 beats for codes 0, 1, 2 and 3. A read yields exactly that many consecutive strobes. A write yields exactly that many consecutive drive cycles.
- R4: Read commands may come every clock. A read whose first sample falls while an earlier burst still has beats left replaces the rest of that burst, and the strobe stream has no gap.
- R5: Bit b of `sd_dqm` in cycle j clears bit b of `rd_byte_vld` for the word sampled in cycle j+2. Bit b covers `dq` bits [8b+7:8b]. A masked word still raises `rd_strobe`, and `rd_byte_vld` is zero whenever `rd_strobe` is low.
- R6: When no read data is due and the previous cycle held no read sample, a write command raises `dq_oe` and `wr_ready` in its own cycle and keeps them high for the burst. In those cycles `dq_o` equals `wr_data`. Outside write beats, `dq_oe` is low and `dq_o` is zero.
- R7: In every write beat `sd_dqm` equals `wr_mask`, which masks that same cycle's data. In every other cycle `sd_dqm` equals `rd_mask`.
- R8: A write command is deferred while read samples are still due, or when the previous cycle held a read sample. Its first beat comes two cycles after the last read sample. `dq_oe` is never high in a cycle that shows a read result, or in the cycle before one.
- R9: After a burst-stop cycle, no further read samples or write beats from earlier commands occur, and a deferred write is dropped. Beats due in the stop cycle itself still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rd | input | 1 | Read command issued this cycle |
| cmd_wr | input | 1 | Write command issued this cycle |
| cmd_stop | input | 1 | Burst-stop command issued this cycle |
| cfg_cl3 | input | 1 | CAS latency select: 1 gives 3, 0 gives 2 |
| cfg_bl | input | 2 | Burst length code: beats = 2**code |
| rd_mask | input | N_BYTES | Read-side byte mask request for the DQM pins |
| wr_data | input | DW | Write word for the current write beat |
| wr_mask | input | N_BYTES | Byte mask for the current write beat |
| wr_ready | output | 1 | High in each write beat; `wr_data` is taken that cycle |
| dq_i | input | DW | DQ pad input |
| dq_o | output | DW | DQ pad output value |
| dq_oe | output | 1 | DQ pad output enable |
| sd_dqm | output | N_BYTES | DQM pin value |
| rd_strobe | output | 1 | One pulse per read beat |
| rd_data | output | DW | Read word for the current strobe |
| rd_byte_vld | output | N_BYTES | Per-byte valid flags of the read word |

## Verification
Single reads at both latencies and at lengths 1, 4 and 8 pin the first-sample cycle and the beat count. The DQ input carries a cycle-stamped value, so the sampled word shows exactly which cycle was captured. Reads spaced one burst apart are contrasted with reads that interrupt a live burst, which separates a gapless hand-over from a restarted count. A masked read places the mask request two cycles ahead of chosen beats, so an off-by-one mask delay shows up on the wrong byte. Writes are issued on an idle bus, during a read, and in the clock after the last read sample, which exposes a missing or doubled turnaround. Burst stops are placed inside a read, inside a write, and on top of a deferred write.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

    localparam int BYTE_W      = 8;
    localparam int N_BYTES     = 2;
    localparam int BL_W        = 2;
    localparam int CNT_W       = 4;
    localparam int MAX_CL      = 3;
    localparam int RD_MASK_LAT = 2;

    // One read command travelling towards its first data cycle
    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] len;
    } rd_tag_t;

    // Burst length code to beat count: 1, 2, 4, 8
    function automatic logic [CNT_W-1:0] burst_beats(input logic [BL_W-1:0] code);
        return CNT_W'(1) << code;
    endfunction

endpackage

// File: rtl/sdr_dp_delay.sv
module sdr_dp_delay #(
    parameter int W     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] stage [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
                end else begin
                    stage[0] <= din;
                    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
                end
            end
            assign dout = stage[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/sdr_dp_rd.sv
module sdr_dp_rd
    import sdr_dp_pkg::*;
#(
    parameter int NB = N_BYTES,
    parameter int DW = NB * BYTE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_rd,
    input  logic            cmd_stop,
    input  logic            cfg_cl3,
    input  logic [BL_W-1:0] cfg_bl,
    input  logic [DW-1:0]   dq_i,
    input  logic [NB-1:0]   mask_at_dq,
    output logic            rd_active,
    output logic            rd_strobe,
    output logic [DW-1:0]   rd_data,
    output logic [NB-1:0]   rd_byte_vld
);
    localparam int CLW = $clog2(MAX_CL);

    rd_tag_t          pipe [MAX_CL];
    rd_tag_t          head;
    logic [CLW-1:0]   lat_idx;
    logic [CNT_W-1:0] left;
    logic             launch;
    logic             beat;

    // Tag in pipe[i] is i+1 cycles old; data arrives when it is CL cycles old
    assign lat_idx = cfg_cl3 ? CLW'(2) : CLW'(1);
    assign head    = pipe[lat_idx];
    assign launch  = head.vld;
    assign beat    = launch | (left != '0);

    always_comb begin
        rd_active = (left != '0);
        for (int i = 0; i < MAX_CL; i++) begin
            if (i <= int'(lat_idx)) rd_active = rd_active | pipe[i].vld;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_CL; i++) pipe[i] <= '0;
            left        <= '0;
            rd_strobe   <= 1'b0;
            rd_data     <= '0;
            rd_byte_vld <= '0;
        end else begin
            rd_strobe   <= beat;
            rd_byte_vld <= beat ? ~mask_at_dq : '0;
            if (beat) rd_data <= dq_i;
            if (cmd_stop) begin
                for (int i = 0; i < MAX_CL; i++) pipe[i] <= '0;
                left <= '0;
            end else begin
                pipe[0].vld <= cmd_rd;
                pipe[0].len <= burst_beats(cfg_bl);
                for (int i = 1; i < MAX_CL; i++) pipe[i] <= pipe[i-1];
                if (launch)            left <= head.len - CNT_W'(1);
                else if (left != '0)   left <= left - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sdr_dp_wr.sv
module sdr_dp_wr
    import sdr_dp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_wr,
    input  logic            cmd_stop,
    input  logic [BL_W-1:0] cfg_bl,
    input  logic            rd_active,
    input  logic            rd_tail,
    output logic            wr_beat
);
    logic             hold;
    logic [CNT_W-1:0] hold_len;
    logic [CNT_W-1:0] left;
    logic             bus_clear;
    logic             go;
    logic [CNT_W-1:0] start_len;

    // rd_tail is high in the cycle after a read sample: that cycle is the turnaround
    assign bus_clear = !rd_active && !rd_tail;
    assign go        = (cmd_wr || hold) && bus_clear && !cmd_stop;
    assign start_len = cmd_wr ? burst_beats(cfg_bl) : hold_len;
    assign wr_beat   = go || (left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= 1'b0;
            hold_len <= '0;
            left     <= '0;
        end else if (cmd_stop) begin
            hold <= 1'b0;
            left <= '0;
        end else if (go) begin
            hold <= 1'b0;
            left <= start_len - CNT_W'(1);
        end else begin
            if (left != '0) left <= left - CNT_W'(1);
            if (cmd_wr) begin
                hold     <= 1'b1;
                hold_len <= burst_beats(cfg_bl);
            end
        end
    end
endmodule

// File: rtl/sdr_dpath.sv
module sdr_dpath
    import sdr_dp_pkg::*;
#(
    parameter int N_BYTES = sdr_dp_pkg::N_BYTES,
    parameter int DW      = N_BYTES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_rd,
    input  logic               cmd_wr,
    input  logic               cmd_stop,
    input  logic               cfg_cl3,
    input  logic [BL_W-1:0]    cfg_bl,
    input  logic [N_BYTES-1:0] rd_mask,
    input  logic [DW-1:0]      wr_data,
    input  logic [N_BYTES-1:0] wr_mask,
    output logic               wr_ready,
    input  logic [DW-1:0]      dq_i,
    output logic [DW-1:0]      dq_o,
    output logic               dq_oe,
    output logic [N_BYTES-1:0] sd_dqm,
    output logic               rd_strobe,
    output logic [DW-1:0]      rd_data,
    output logic [N_BYTES-1:0] rd_byte_vld
);
    logic               wr_beat;
    logic               rd_active;
    logic [N_BYTES-1:0] mask_at_dq;

    // Write mask acts in its own cycle; read mask acts RD_MASK_LAT cycles later
    assign sd_dqm   = wr_beat ? wr_mask : rd_mask;
    assign wr_ready = wr_beat;
    assign dq_oe    = wr_beat;
    assign dq_o     = wr_beat ? wr_data : '0;

    sdr_dp_delay #(.W(N_BYTES), .DEPTH(RD_MASK_LAT)) u_mask_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (sd_dqm),
        .dout (mask_at_dq)
    );

    sdr_dp_rd #(.NB(N_BYTES), .DW(DW)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .cmd_rd      (cmd_rd),
        .cmd_stop    (cmd_stop),
        .cfg_cl3     (cfg_cl3),
        .cfg_bl      (cfg_bl),
        .dq_i        (dq_i),
        .mask_at_dq  (mask_at_dq),
        .rd_active   (rd_active),
        .rd_strobe   (rd_strobe),
        .rd_data     (rd_data),
        .rd_byte_vld (rd_byte_vld)
    );

    sdr_dp_wr u_wr (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_stop  (cmd_stop),
        .cfg_bl    (cfg_bl),
        .rd_active (rd_active),
        .rd_tail   (rd_strobe),
        .wr_beat   (wr_beat)
    );
endmodule

// File: rtl/sdr_dpath_chk.sv
module sdr_dpath_chk #(
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_wr,
    input logic          cmd_stop,
    input logic          dq_oe,
    input logic [NB-1:0] wr_mask,
    input logic [NB-1:0] sd_dqm,
    input logic          rd_strobe,
    input logic [NB-1:0] rd_byte_vld
);
    AST_RD_MASK_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> (rd_byte_vld == ~$past(sd_dqm, 3))); // R5

    AST_NO_STRAY_BYTE_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |-> (rd_byte_vld == '0)); // R5

    AST_WR_MASK_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (sd_dqm == wr_mask)); // R7

    AST_NO_DRIVE_ON_RETURN: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> !dq_oe); // R8

    AST_NO_CAPTURE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
        dq_oe |=> !rd_strobe); // R8

    AST_STOP_ENDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cmd_stop ##1 !cmd_wr) |-> !dq_oe); // R9

    AST_STOP_ENDS_READ: assert property (@(posedge clk) disable iff (rst)
        cmd_stop |=> ##1 !rd_strobe); // R9
endmodule

bind sdr_dpath sdr_dpath_chk #(.NB(N_BYTES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (cmd_wr),
    .cmd_stop    (cmd_stop),
    .dq_oe       (dq_oe),
    .wr_mask     (wr_mask),
    .sd_dqm      (sd_dqm),
    .rd_strobe   (rd_strobe),
    .rd_byte_vld (rd_byte_vld)
);

// File: tb/sdr_dpath_test.sv
`timescale 1ns/1ps
module sdr_dpath_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int DW = 16;
    localparam int SPAN = 28;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_stop = 1'b0, cfg_cl3 = 1'b0;
    logic [1:0]    cfg_bl = '0;
    logic [NB-1:0] rd_mask = '0, wr_mask = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] dq_i, dq_o, rd_data;
    logic          wr_ready, dq_oe, rd_strobe;
    logic [NB-1:0] sd_dqm, rd_byte_vld;
    int            cyc = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    // Cycle-stamped pad input: the captured word shows which cycle was sampled
    assign dq_i = 16'h1000 + 16'(cyc);

    sdr_dpath uut (
        .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop),
        .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl), .rd_mask(rd_mask), .wr_data(wr_data),
        .wr_mask(wr_mask), .wr_ready(wr_ready), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .sd_dqm(sd_dqm), .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_byte_vld(rd_byte_vld)
    );

    task automatic check(input string req, input string what, input int k,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at step %0d: actual %h expected %h", req, what, k, act, exp);
        end
    endtask

    function automatic logic [31:0] rng(input int a, input int b);
        logic [31:0] v = '0;
        for (int i = a; i <= b; i++) v[i] = 1'b1;
        return v;
    endfunction

    // Drives one stimulus pattern step by step and checks every output each step
    task automatic run_pat(input string req, input logic cl3, input logic [1:0] bl,
                           input logic [31:0] rdc, input logic [31:0] wrc,
                           input logic [31:0] stp, input logic [31:0] mhi,
                           input logic [31:0] mlo, input logic [31:0] es,
                           input logic [31:0] eo);
        logic [NB-1:0] exp_bv;
        cfg_cl3 = cl3;
        cfg_bl  = bl;
        for (int k = 0; k < SPAN; k++) begin
            @(negedge clk);
            cmd_rd   = rdc[k];
            cmd_wr   = wrc[k];
            cmd_stop = stp[k];
            rd_mask  = {mhi[k], mlo[k]};
            wr_mask  = 2'(k);
            wr_data  = 16'h5000 + 16'(k);
            #1;
            check(req, "rd_strobe", k, 32'(rd_strobe), 32'(es[k]));
            exp_bv = '0;
            if (es[k]) begin
                check(req, "rd_data", k, 32'(rd_data), 32'(16'h1000 + 16'(cyc - 1)));
                exp_bv = 2'b11;
                if (k >= 3) exp_bv = ~{mhi[k-3], mlo[k-3]};
            end
            check(req, "rd_byte_vld", k, 32'(rd_byte_vld), 32'(exp_bv));
            check(req, "dq_oe", k, 32'(dq_oe), 32'(eo[k]));
            check(req, "wr_ready", k, 32'(wr_ready), 32'(eo[k]));
            if (eo[k]) begin
                check(req, "dq_o", k, 32'(dq_o), 32'(wr_data));
                check(req, "sd_dqm", k, 32'(sd_dqm), 32'(wr_mask));
            end else begin
                check(req, "dq_o", k, 32'(dq_o), 32'h0);
                check(req, "sd_dqm", k, 32'(sd_dqm), 32'(rd_mask));
            end
        end
        @(negedge clk);
        {cmd_rd, cmd_wr, cmd_stop} = '0;
        rd_mask = '0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "rd_strobe in reset", 0, 32'(rd_strobe), 0);
        check("R1", "dq_oe in reset", 0, 32'(dq_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "rd_strobe", 1, 32'(rd_strobe), 0);
        check("R1", "rd_byte_vld", 1, 32'(rd_byte_vld), 0);
        check("R1", "dq_oe", 1, 32'(dq_oe), 0);
        check("R1", "wr_ready", 1, 32'(wr_ready), 0);
    endtask

    task automatic t_read_cl2_single();   // R2
        run_pat("R2", 1'b0, 2'd0, 32'h1, 0, 0, 0, 0, rng(3, 3), 0);
    endtask

    task automatic t_read_cl3_four();     // R2 and R3
        run_pat("R2/R3", 1'b1, 2'd2, 32'h1, 0, 0, 0, 0, rng(4, 7), 0);
    endtask

    task automatic t_read_eight();        // R3
        run_pat("R3", 1'b0, 2'd3, 32'h1, 0, 0, 0, 0, rng(3, 10), 0);
    endtask

    task automatic t_read_back_to_back(); // R4
        run_pat("R4", 1'b0, 2'd1, 32'h5, 0, 0, 0, 0, rng(3, 6), 0);
        run_pat("R4", 1'b1, 2'd0, rng(0, 3), 0, 0, 0, 0, rng(4, 7), 0);
    endtask

    task automatic t_read_interrupt();    // R4: second read cuts the first short
        run_pat("R4", 1'b0, 2'd2, 32'h5, 0, 0, 0, 0, rng(3, 8), 0);
    endtask

    task automatic t_read_masked();       // R5: mask two cycles ahead of chosen beats
        run_pat("R5", 1'b1, 2'd2, 32'h1, 0, 0, 32'h0000_000C, 32'h0000_0008, rng(4, 7), 0);
    endtask

    task automatic t_write_idle();        // R6 and R7
        run_pat("R6/R7", 1'b0, 2'd2, 0, 32'h2, 0, 0, 0, 0, rng(1, 4));
    endtask

    task automatic t_write_after_read();  // R8
        run_pat("R8", 1'b0, 2'd1, 32'h1, 32'h2, 0, 0, 0, rng(3, 4), rng(5, 6));
        run_pat("R8", 1'b0, 2'd0, 32'h1, 32'h8, 0, 0, 0, rng(3, 3), rng(4, 4));
    endtask

    task automatic t_stop();              // R9
        run_pat("R9", 1'b0, 2'd3, 0, 32'h1, 32'h4, 0, 0, 0, rng(0, 2));
        run_pat("R9", 1'b0, 2'd3, 32'h1, 0, 32'h10, 0, 0, rng(3, 5), 0);
        run_pat("R9", 1'b0, 2'd1, 32'h1, 32'h2, 32'h8, 0, 0, rng(3, 4), 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_read_cl2_single();
        t_read_cl3_four();
        t_read_eight();
        t_read_back_to_back();
        t_read_interrupt();
        t_read_masked();
        t_write_idle();
        t_write_after_read();
        t_stop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule